// File: doc/BRIEF.md
# Cascaded Boxcar Gaussian Pulse-Shaping Filter

This block is a lowpass filter without multipliers, placed in the pulse-shaping path of a GMSK-style modulator. Its impulse response is close to a Gaussian. It gets that shape from a fact about convolution: a rectangular window convolved with itself several times tends toward a bell curve. The filter therefore applies four equal-weight running sums of `TAPS` samples one after another.

Each running sum is split into two parts, an accumulating integrator and a difference taken against a copy delayed by `TAPS` samples. The design keeps all four integrators in front and all four differencers behind them, so the datapath uses only adders, subtractors and registers. The accumulators are sized so that two's-complement wraparound in the integrators cancels exactly in the differencers.

Input samples arrive on a signed bus with a valid strobe. The filter state moves forward only on cycles where that strobe is high, so gaps in the input stream are transparent to the filter. The output carries the full gain of `TAPS`^4. When the `NORM` parameter is set, the output is instead arithmetically shifted back to the input width, which gives unity DC gain.

Top module: `gauss_boxcar_filter`

## Requirements
- R1: When `rst_n` is sampled low at a rising edge, then after that edge `dout` is 0 and `dout_vld` is 0. `dout` stays 0 until a nonzero sample has been accepted.
- R2: A single accepted sample of value 1 followed by zeros gives 4*TAPS-3 consecutive nonzero outputs. These outputs are the coefficients of (1+z^-1+...+z^-(TAPS-1))^4 and add up to TAPS^4 (4096 for TAPS=8).
- R3: A constant input x held for at least 4*TAPS-3 accepted samples gives a steady output of x*TAPS^4.
- R4: `dout_vld` equals `din_vld` delayed by exactly 8 clock cycles, one register for each of the four integrators and four differencers.
- R5: Cycles with `din_vld` low do not affect the filter. The output sequence depends only on the accepted samples, and `dout` holds its value whenever `dout_vld` is low.
- R6: Full-scale inputs held long enough to wrap every integrator still give exact results. A run of -2^(DATA_W-1) settles at -2^(DATA_W-1)*TAPS^4, and a run of 2^(DATA_W-1)-1 settles at (2^(DATA_W-1)-1)*TAPS^4.
- R7: With `NORM`=1 and `TAPS` a power of two, `dout` is DATA_W bits wide and equals floor(full-gain result / TAPS^4).
- R8: For any sequence of accepted samples, each output is the sum over k of h[k]*x[n-k], where h is the response from R2 (an exact linear convolution).
- R9: A reset applied in the middle of a stream discards all stored history. The first response after the reset depends only on samples accepted after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din_vld | input | 1 | High when `din` carries a sample to accept |
| din | input | DATA_W | Signed two's-complement input sample |
| dout_vld | output | 1 | High when `dout` carries a new result |
| dout | output | OUT_W | Signed result: DATA_W+4*clog2(TAPS) bits at full gain, DATA_W bits when `NORM`=1 |

## Verification
The integrators wrap around only after long runs of extreme samples. Their cancellation in the differencers is invisible at the ports unless the output is compared exactly against a linear convolution. The stimulus therefore includes runs of full-scale negative samples and then full-scale positive samples, each long enough to wrap the last integrator many times over, and the two settled values it checks sit right at the edges of the output range. Irregular gaps in `din_vld` are mixed into a pseudo-random stream so that stalls can occur while the pipeline is partly full.

// File: rtl/gbf_pkg.sv
// Shared constants and sizing helpers for the cascaded boxcar filter.
// Assumes the boxcar length is at least 2.
package gbf_pkg;

    // Number of boxcar sections in the cascade.
    localparam int STAGES = 4;

    // Register stages from an accepted input to its output.
    localparam int LATENCY = 2 * STAGES;

    // Bits of growth needed for the cascade gain of taps^STAGES.
    function automatic int growth(input int taps);
        return STAGES * $clog2(taps);
    endfunction

endpackage

// File: rtl/gbf_integ.sv
// One integrator section: adds each accepted sample into a wrapping
// accumulator and presents the accumulator as a registered output.
// Assumes W is wide enough that the downstream differencers undo the wrap.
module gbf_integ #(
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_dat,
    output logic                out_vld,
    output logic signed [W-1:0] out_dat
);

    // Accumulate on accepted samples and pass the strobe one cycle on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_dat <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_dat <= out_dat + in_dat;
            end
        end
    end

endmodule

// File: rtl/gbf_comb.sv
// One differencer section: subtracts the input seen DEPTH accepted
// samples earlier from the current input.
// Assumes its strobe only advances the delay line, never idle cycles.
module gbf_comb #(
    parameter int W     = 24,
    parameter int DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_dat,
    output logic                out_vld,
    output logic signed [W-1:0] out_dat
);

    logic signed [W-1:0] hist [DEPTH];

    // Shift the sample history on accepted samples only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist[i] <= '0;
            end
        end else if (in_vld) begin
            hist[0] <= in_dat;
            for (int i = 1; i < DEPTH; i++) begin
                hist[i] <= hist[i-1];
            end
        end
    end

    // Form the delayed difference and pass the strobe one cycle on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_dat <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_dat <= in_dat - hist[DEPTH-1];
            end
        end
    end

endmodule

// File: rtl/gauss_boxcar_filter.sv
// Four running-sum sections in cascade, built as four integrators
// followed by four differencers. Gain is TAPS^4. With NORM set, the
// result is shifted back to DATA_W bits (TAPS must be a power of two).
module gauss_boxcar_filter
    import gbf_pkg::*;
#(
    parameter int  DATA_W = 12,
    parameter int  TAPS   = 8,
    parameter bit  NORM   = 1'b0,
    localparam int ACC_W  = DATA_W + growth(TAPS),
    localparam int OUT_W  = NORM ? DATA_W : ACC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    din_vld,
    input  logic signed [DATA_W-1:0] din,
    output logic                    dout_vld,
    output logic signed [OUT_W-1:0] dout
);

    localparam int GROW  = ACC_W - DATA_W;

    logic signed [ACC_W-1:0] i_dat [STAGES+1];
    logic                    i_vld [STAGES+1];
    logic signed [ACC_W-1:0] c_dat [STAGES+1];
    logic                    c_vld [STAGES+1];

    // Sign-extend the input into the accumulator width.
    assign i_dat[0] = {{GROW{din[DATA_W-1]}}, din};
    assign i_vld[0] = din_vld;

    // Integrator chain.
    for (genvar s = 0; s < STAGES; s++) begin : g_integ
        gbf_integ #(.W(ACC_W)) u_integ (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_vld (i_vld[s]),
            .in_dat (i_dat[s]),
            .out_vld(i_vld[s+1]),
            .out_dat(i_dat[s+1])
        );
    end

    assign c_dat[0] = i_dat[STAGES];
    assign c_vld[0] = i_vld[STAGES];

    // Differencer chain.
    for (genvar s = 0; s < STAGES; s++) begin : g_comb
        gbf_comb #(.W(ACC_W), .DEPTH(TAPS)) u_comb (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_vld (c_vld[s]),
            .in_dat (c_dat[s]),
            .out_vld(c_vld[s+1]),
            .out_dat(c_dat[s+1])
        );
    end

    assign dout_vld = c_vld[STAGES];

    // Output scaling: full gain, or arithmetic shift back to unity gain.
    if (NORM) begin : g_norm
        assign dout = OUT_W'(c_dat[STAGES] >>> GROW);
    end else begin : g_full
        assign dout = c_dat[STAGES];
    end

endmodule

// File: rtl/gbf_checker.sv
// Port-level properties of the cascaded boxcar filter, bound to every
// instance of the top module.
module gbf_checker #(
    parameter int DATA_W = 12,
    parameter int OUT_W  = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     din_vld,
    input logic signed [DATA_W-1:0] din,
    input logic                     dout_vld,
    input logic signed [OUT_W-1:0]  dout
);

    logic [3:0] since_rst;
    logic       seen_data;

    // Count cycles since reset, saturating, to bound history lookups.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 4'd15) since_rst <= since_rst + 4'd1;
    end

    // Remember whether any nonzero sample has been accepted since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_data <= 1'b0;
        else if (din_vld && din != '0) seen_data <= 1'b1;
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (dout == '0 && !dout_vld));

    p_quiet_until_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_data |-> dout == '0);

    p_valid_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst >= 4'd8 |-> dout_vld == $past(din_vld, 8));

    p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd1 && !dout_vld) |-> $stable(dout));

endmodule

bind gauss_boxcar_filter gbf_checker #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .din_vld (din_vld),
    .din     (din),
    .dout_vld(dout_vld),
    .dout    (dout)
);

// File: tb/gauss_boxcar_filter_tb.sv
module gauss_boxcar_filter_tb;

    localparam int DATA_W = 12;
    localparam int TAPS   = 8;
    localparam int ACC_W  = DATA_W + 4 * $clog2(TAPS);
    localparam int HLEN   = 4 * TAPS - 3;
    localparam int SH     = 4 * $clog2(TAPS);
    localparam longint GAIN = longint'(TAPS) ** 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din_vld = 1'b0;
    logic signed [DATA_W-1:0] din = '0;
    logic dout_vld, nout_vld;
    logic signed [ACC_W-1:0]  dout;
    logic signed [DATA_W-1:0] nout;

    always #4 clk = ~clk;

    gauss_boxcar_filter #(.DATA_W(DATA_W), .TAPS(TAPS), .NORM(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .din_vld(din_vld), .din(din),
        .dout_vld(dout_vld), .dout(dout));

    gauss_boxcar_filter #(.DATA_W(DATA_W), .TAPS(TAPS), .NORM(1'b1)) u_dut_norm (
        .clk(clk), .rst_n(rst_n), .din_vld(din_vld), .din(din),
        .dout_vld(nout_vld), .dout(nout));

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";

    longint h [HLEN];
    int     hist [$];
    longint exp_full [$];
    longint exp_norm [$];

    longint mon_sum, mon_last, mon_nlast;
    int     mon_nz, mon_cnt;

    task automatic check(input string req, input longint got, input longint want);
        compared++;
        if (got != want) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d", req, got, want);
        end
    endtask

    // Impulse response: boxcar convolved with itself four times.
    task automatic build_h();
        longint a [HLEN];
        longint b [HLEN];
        for (int k = 0; k < HLEN; k++) a[k] = (k < TAPS) ? 1 : 0;
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < HLEN; k++) begin
                b[k] = 0;
                for (int j = 0; j < TAPS; j++)
                    if (k - j >= 0) b[k] += a[k-j];
            end
            a = b;
        end
        h = a;
    endtask

    // Drive one sample (or an idle cycle) and record the expected result.
    task automatic put(input bit v, input int x);
        longint acc;
        @(negedge clk);
        din_vld = v;
        din = DATA_W'(x);
        if (v) begin
            hist.push_back(x);
            acc = 0;
            for (int k = 0; k < HLEN; k++)
                if (hist.size() - 1 - k >= 0) acc += h[k] * hist[hist.size()-1-k];
            exp_full.push_back(acc);
            exp_norm.push_back(acc >>> SH);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 0);
    endtask

    task automatic clear_mon();
        mon_sum = 0; mon_nz = 0; mon_cnt = 0;
    endtask

    // Scoreboard: every valid output against the convolution model (R8).
    always @(negedge clk) begin
        if (dout_vld) begin
            if (exp_full.size() == 0) check({cur_req, " R8 unexpected output"}, 1, 0);
            else check({cur_req, " R8 full"}, dout, exp_full.pop_front());
            mon_sum += dout;
            mon_last = dout;
            mon_cnt++;
            if (dout != 0) mon_nz++;
        end
        if (nout_vld) begin
            if (exp_norm.size() == 0) check({cur_req, " R7 unexpected output"}, 1, 0);
            else check({cur_req, " R7 normalised"}, nout, exp_norm.pop_front());
            mon_nlast = nout;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        hist.delete(); exp_full.delete(); exp_norm.delete();
        rst_n = 1'b1;
    endtask

    task automatic t_reset_r1();
        cur_req = "R1";
        do_reset();
        check("R1 dout after reset", dout, 0);
        check("R1 vld after reset", dout_vld, 0);
        check("R1 norm dout after reset", nout, 0);
        idle(12);
        check("R1 dout quiet without data", dout, 0);
    endtask

    task automatic t_impulse_r2();
        cur_req = "R2";
        clear_mon();
        put(1'b1, 1);
        for (int i = 0; i < HLEN + 4; i++) put(1'b1, 0);
        idle(12);
        check("R2 impulse sum", mon_sum, GAIN);
        check("R2 nonzero taps", mon_nz, HLEN);
        check("R2 output count", mon_cnt, HLEN + 5);
    endtask

    task automatic t_latency_r4();
        int n;
        cur_req = "R4";
        do_reset();
        put(1'b1, 5);
        n = 0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            din_vld = 1'b0;
            if (dout_vld && n == 0) n = i;
        end
        check("R4 cycles to dout_vld", n, 8);
        idle(4);
    endtask

    task automatic t_dc_r3();
        cur_req = "R3";
        do_reset();
        for (int i = 0; i < HLEN + 6; i++) put(1'b1, 100);
        idle(12);
        check("R3 steady DC output", mon_last, 100 * GAIN);
        check("R3 normalised DC", mon_nlast, 100);
    endtask

    task automatic t_fullscale_r6();
        cur_req = "R6";
        do_reset();
        for (int i = 0; i < 80; i++) put(1'b1, -2048);
        idle(12);
        check("R6 negative full scale", mon_last, -2048 * GAIN);
        check("R6 negative normalised", mon_nlast, -2048);
        for (int i = 0; i < 80; i++) put(1'b1, 2047);
        idle(12);
        check("R6 positive full scale", mon_last, 2047 * GAIN);
        check("R6 positive normalised", mon_nlast, 2047);
    endtask

    task automatic t_gaps_r5();
        logic [15:0] lfsr = 16'hACE1;
        logic signed [ACC_W-1:0] held;
        cur_req = "R5";
        do_reset();
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:2] == 2'b00) begin
                put(1'b0, 0);
                @(posedge clk);
                held = dout;
                #1;
                if (!dout_vld) check("R5 dout held while idle", dout, held);
            end else begin
                put(1'b1, int'($signed(lfsr[11:0])));
            end
        end
        idle(12);
        check("R5 all outputs drained", exp_full.size(), 0);
    endtask

    task automatic t_midreset_r9();
        cur_req = "R9";
        do_reset();
        for (int i = 0; i < 20; i++) put(1'b1, 1500 - 150 * i);
        do_reset();
        check("R9 dout cleared", dout, 0);
        clear_mon();
        put(1'b1, 3);
        for (int i = 0; i < HLEN + 2; i++) put(1'b1, 0);
        idle(12);
        check("R9 clean impulse sum", mon_sum, 3 * GAIN);
        check("R9 clean nonzero count", mon_nz, HLEN);
    endtask

    initial begin
        #(8 * 150000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        build_h();
        clear_mon();
        t_reset_r1();
        t_impulse_r2();
        t_latency_r4();
        t_dc_r3();
        t_fullscale_r6();
        t_gaps_r5();
        t_midreset_r9();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule